// File: doc/BRIEF.md
# Dual-Clock FIFO with Quadrant Direction Latch

This block carries data words from one clock domain to another clock domain whose clock has no phase or frequency relation to the first. Words are held in a dual-port storage array. The write side stores each word at the address of its own pointer, and the read side presents the word at its own pointer address. Both pointers step through a Gray sequence, so one bit changes per step. A comparator that spans the two domains then sees only one settled value or the next.

Pointer equality alone cannot separate a full array from an empty one. The two most significant Gray bits of each pointer name its quadrant, and a direction latch records which one applies. The latch is set when the writer trails the reader by one quadrant, which means the array is filling up. It is cleared when the writer leads the reader by one quadrant, which means the array is draining. Pointer equality gated by the direction gives a raw full or a raw empty condition.

Each raw condition feeds a flip-flop in its own domain. The raw condition drives both the flip-flop's asynchronous preset and its D input. A flag therefore rises at once and falls only on an edge of its own clock. The read data is shown ahead of the pop: `rd_data` holds the oldest unread word whenever `empty` is low.

Top module: `afifo_quad`

## Requirements
- R1: Each pointer advances by one Gray step per accepted request, so consecutive pointer values differ in at most one bit.
- R2: Words leave the read port in the order in which they were accepted at the write port, across any number of pointer wraparounds.
- R3: `full` is high whenever 2^ADDR_W words are unread. A write request made while `full` is high is ignored, stores nothing and does not move the write pointer. `full` is never low while 2^ADDR_W words are unread.
- R4: `empty` is low only while at least one unread word exists. A read request made while `empty` is high does not move the read pointer. The last stored word can always be read out.
- R5: Quadrants follow the Gray order 00, 01, 11, 10. The direction latch is set when the next quadrant after the write quadrant equals the read quadrant. It is cleared when the next quadrant after the read quadrant equals the write quadrant.
- R6: After `arst_n` is low, both pointers are zero, the direction latch is clear, `empty` is high and `full` is low. Each domain leaves reset on an edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst_n | input | 1 | Asynchronous active-low reset, released separately into each domain |
| wclk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request, sampled on rising `wclk` |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry; writes are ignored |
| rclk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request (pop), sampled on rising `rclk` |
| rd_data | output | DATA_W | Oldest unread word, valid while `empty` is low |
| empty | output | 1 | No unread entry; reads are ignored |

## Verification
The bench builds the block with ADDR_W=3 and DATA_W=8. This gives eight entries and quadrants two entries wide. The pointers wrap and the direction latch flips many times in a few thousand cycles. At this size a full fill and a full drain take only a handful of cycles, so the bench can push writes past the full point and reads past the empty point. It can also sweep the two request rates so the occupancy moves between the two ends of the array.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  typedef logic [1:0] quad_t;

  // Successor of a quadrant in the Gray order 00 -> 01 -> 11 -> 10 -> 00
  function automatic quad_t quad_succ(input quad_t q);
    return {q[0], ~q[1]};
  endfunction

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/afifo_rst_sync.sv
module afifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/afifo_gptr.sv
module afifo_gptr
  import afifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] bin,
  output logic [ADDR_W-1:0] gray
);
  logic [ADDR_W-1:0] bin_d;
  logic [ADDR_W-1:0] gray_d;
  logic [31:0]       wide;

  always_comb begin
    bin_d  = bin;
    gray_d = gray;
    wide   = '0;
    if (step) begin
      bin_d  = bin + 1'b1;
      wide   = bin2gray(32'(bin_d));
      gray_d = wide[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin  <= '0;
      gray <= '0;
    end else if (step) begin
      bin  <= bin_d;
      gray <= gray_d;
    end
  end
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int ENTRIES = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/afifo_dir.sv
module afifo_dir
  import afifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] wgray,
  input  logic [ADDR_W-1:0] rgray,
  output logic              q_set,
  output logic              q_clr,
  output logic              dir_q
);
  quad_t wq, rq;

  always_comb begin
    wq    = wgray[ADDR_W-1 -: 2];
    rq    = rgray[ADDR_W-1 -: 2];
    q_set = (quad_succ(wq) == rq);
    q_clr = (quad_succ(rq) == wq);
  end

  always_latch begin
    if (!arst_n)    dir_q <= 1'b0;
    else if (q_set) dir_q <= 1'b1;
    else if (q_clr) dir_q <= 1'b0;
  end
endmodule

// File: rtl/afifo_flag.sv
module afifo_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n or posedge raw) begin
    if (!rst_n)   flag <= RST_VAL;
    else if (raw) flag <= 1'b1;
    else          flag <= 1'b0;
  end
endmodule

// File: rtl/afifo_quad.sv
module afifo_quad
  import afifo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              arst_n,
  input  logic              wclk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rclk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);
  logic              w_rst_n, r_rst_n;
  logic              wr_ok, rd_ok;
  logic [ADDR_W-1:0] wbin, wgray, rbin, rgray;
  logic              q_set, q_clr, dir_q;
  logic              ptr_eq, raw_full, raw_empty;

  afifo_rst_sync #(.STAGES(2)) u_wrst (.clk(wclk), .arst_n(arst_n), .rst_n(w_rst_n));
  afifo_rst_sync #(.STAGES(2)) u_rrst (.clk(rclk), .arst_n(arst_n), .rst_n(r_rst_n));

  assign wr_ok = wr_en & ~full;
  assign rd_ok = rd_en & ~empty;

  afifo_gptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk(wclk), .rst_n(w_rst_n), .step(wr_ok), .bin(wbin), .gray(wgray));
  afifo_gptr #(.ADDR_W(ADDR_W)) u_rptr (
    .clk(rclk), .rst_n(r_rst_n), .step(rd_ok), .bin(rbin), .gray(rgray));

  afifo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .wclk(wclk), .we(wr_ok), .waddr(wbin), .wdata(wr_data),
    .raddr(rbin), .rdata(rd_data));

  afifo_dir #(.ADDR_W(ADDR_W)) u_dir (
    .arst_n(arst_n), .wgray(wgray), .rgray(rgray),
    .q_set(q_set), .q_clr(q_clr), .dir_q(dir_q));

  always_comb begin
    ptr_eq    = (wgray == rgray);
    raw_full  = ptr_eq & dir_q;
    raw_empty = ptr_eq & ~dir_q;
  end

  afifo_flag #(.RST_VAL(1'b0)) u_full (
    .clk(wclk), .rst_n(w_rst_n), .raw(raw_full), .flag(full));
  afifo_flag #(.RST_VAL(1'b1)) u_empty (
    .clk(rclk), .rst_n(r_rst_n), .raw(raw_empty), .flag(empty));
endmodule

// File: rtl/afifo_quad_chk.sv
module afifo_quad_chk
  import afifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              wclk,
  input logic              rclk,
  input logic              w_rst_n,
  input logic              r_rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              full,
  input logic              empty,
  input logic [ADDR_W-1:0] wgray,
  input logic [ADDR_W-1:0] rgray,
  input logic [ADDR_W-1:0] wbin,
  input logic [ADDR_W-1:0] rbin,
  input logic              q_set,
  input logic              q_clr,
  input logic              dir_q
);
  assert_wgray_step_R1: assert property (@(posedge wclk) disable iff (!w_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R1: assert property (@(posedge rclk) disable iff (!r_rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!w_rst_n)
    (full && wr_en) |=> $stable(wbin));

  assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!r_rst_n)
    (empty && rd_en) |=> $stable(rbin));

  assert_dir_set_R5: assert property (@(posedge wclk) disable iff (!w_rst_n)
    q_set |-> dir_q);

  assert_dir_clr_R5: assert property (@(posedge rclk) disable iff (!r_rst_n)
    q_clr |-> !dir_q);

  assert_reset_empty_R6: assert property (@(posedge rclk) disable iff (!r_rst_n)
    $rose(r_rst_n) |-> empty);
endmodule

bind afifo_quad afifo_quad_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .w_rst_n(w_rst_n), .r_rst_n(r_rst_n),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty),
  .wgray(wgray), .rgray(rgray), .wbin(wbin), .rbin(rbin),
  .q_set(q_set), .q_clr(q_clr), .dir_q(dir_q));

// File: tb/tb_afifo_quad.sv
`timescale 1ns/1ps
module tb_afifo_quad;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              arst_n;
  logic              wclk, rclk;
  logic              wr_en, rd_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic              full, empty;

  int errors = 0;
  int checks = 0;
  int wr_pct = 0;
  int rd_pct = 0;
  bit running = 0;
  int reads_done = 0;
  logic [DATA_W-1:0] model [$];
  logic [DATA_W-1:0] next_word = '0;

  afifo_quad #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .arst_n(arst_n), .wclk(wclk), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rclk(rclk), .rd_en(rd_en), .rd_data(rd_data), .empty(empty));

  initial wclk = 0;
  always #2.5 wclk = ~wclk;     // 200 MHz
  initial rclk = 0;
  always #3.65 rclk = ~rclk;    // unrelated read clock

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Writer: requests at falling edge, acceptance decided from full
  initial begin
    wr_en = 0; wr_data = '0;
    forever begin
      bit acc;
      @(negedge wclk);
      if (running && ($urandom_range(99) < wr_pct)) begin
        wr_en = 1; wr_data = next_word;
      end else wr_en = 0;
      #1;
      acc = wr_en && !full;
      if (running && !full)  // R3: full cannot be low with all entries unread
        check(model.size() < DEPTH, "R3 full low at depth", model.size(), DEPTH - 1);
      @(posedge wclk);
      if (acc) begin
        model.push_back(wr_data);
        next_word = next_word + 1'b1;
      end
    end
  end

  // Reader: compares head word on every accepted pop
  initial begin
    rd_en = 0;
    forever begin
      bit acc;
      @(negedge rclk);
      rd_en = running && ($urandom_range(99) < rd_pct);
      #1;
      acc = rd_en && !empty;
      if (running && !empty)  // R4: no stale data offered
        check(model.size() > 0, "R4 empty low with nothing stored", model.size(), 1);
      if (acc && model.size() > 0)  // R2 order, R1 pointer wrap sequence
        check(rd_data == model[0], "R2 data order", rd_data, model[0]);
      @(posedge rclk);
      if (acc && model.size() > 0) begin
        void'(model.pop_front());
        reads_done++;
      end
    end
  end

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    arst_n = 0;
    repeat (4) @(posedge wclk);
    #1;
    check(empty == 1'b1, "R6 empty in reset", empty, 1);
    check(full == 1'b0, "R6 full in reset", full, 0);
    arst_n = 1;
    repeat (6) @(posedge rclk);
    #1;
    check(empty == 1'b1, "R6 empty after reset", empty, 1);
    check(full == 1'b0, "R6 full after reset", full, 0);
    running = 1;

    // Fill beyond capacity: extra writes must be dropped
    wr_pct = 100; rd_pct = 0;
    repeat (4 * DEPTH) @(posedge wclk);
    @(negedge wclk); #1;
    check(full == 1'b1, "R3 full after fill", full, 1);
    check(model.size() == DEPTH, "R3 writes while full ignored", model.size(), DEPTH);

    // Drain beyond empty: last word must come out, extra reads dropped
    wr_pct = 0; rd_pct = 100;
    repeat (4 * DEPTH) @(posedge rclk);
    @(negedge rclk); #1;
    check(reads_done == DEPTH, "R4 last word readable", reads_done, DEPTH);
    check(empty == 1'b1, "R4 empty after drain", empty, 1);
    check(model.size() == 0, "R4 model drained", model.size(), 0);
    @(negedge wclk); #1;
    check(full == 1'b0, "R3 full released", full, 0);

    // One word after empty reads: read pointer must not have moved
    wr_pct = 100; rd_pct = 0;
    @(posedge wclk); @(negedge wclk); #1;
    wr_pct = 0;
    repeat (4) @(posedge rclk);
    rd_pct = 100;
    repeat (4) @(posedge rclk);
    @(negedge rclk); #1;
    check(reads_done == DEPTH + 1, "R4 pointer held while empty", reads_done, DEPTH + 1);

    // Mixed rates: wraparound and direction latch flips (R5)
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: begin wr_pct = 90; rd_pct = 40; end
        1: begin wr_pct = 40; rd_pct = 90; end
        2: begin wr_pct = 70; rd_pct = 70; end
        default: begin wr_pct = 100; rd_pct = 60; end
      endcase
      repeat (2000) @(posedge wclk);
    end
    @(negedge wclk); #1;
    check(next_word != '0 || reads_done > DEPTH, "R5 traffic flowed", reads_done, DEPTH + 1);

    wr_pct = 0; rd_pct = 100;
    repeat (6 * DEPTH) @(posedge rclk);
    @(negedge rclk); #1;
    check(model.size() == 0, "R5 final drain complete", model.size(), 0);
    check(empty == 1'b1, "R4 empty at end", empty, 1);
    check(reads_done > 4 * DEPTH, "R2 many wraps read", reads_done, 4 * DEPTH + 1);
    running = 0;
    finish_run();
  end
endmodule